// File: doc/BRIEF.md
# Two-Wire Byte Memory Target

This block is a target on a two-wire serial bus. It sits in front of a 2048-byte array and keeps an 11-bit address latch. The bus pins are sampled into the system clock domain. The block answers the bus by pulling SDA low through an open-drain enable, and a protect input can lock the whole array against writes.

A transaction opens with a device byte. That byte holds a fixed 4-bit type code, three page bits that pick one 256-byte page, and a direction bit. A write then sends one word-address byte, which sets the low eight address bits, followed by any number of data bytes. A read sends no address: it takes the page from the device byte and continues from the low bits held in the latch. A random read is therefore a write that stops after the address byte, followed by a repeated START and a read.

The latch steps once per data byte and wraps over the whole 11-bit range. A write lands in the array as its eighth bit is taken, so there is never a busy period.

Top module: `i2c_fram_target`

## Requirements
- R1: A device byte of form {4'b1010, page[2:0], rw} (MSB first, rw=0 write, rw=1 read) is acknowledged, and the page bits are loaded into address bits [10:8].
- R2: A device byte whose upper four bits are not 4'b1010 is not acknowledged, and every later byte is not acknowledged either until the next START.
- R3: In a write, the byte after the device byte is not data. It sets address bits [7:0], is always acknowledged, and together with the page forms the 11-bit address.
- R4: A read sends no address byte. Data comes from {page from the device byte, latched bits [7:0]}, so a read continues from the byte after the previous access.
- R5: The address steps by one after every transferred data byte and wraps from 7FFh to 000h, also across page boundaries. A transfer may be any length.
- R6: A read shifts out 8 bits MSB first. An ACK from the controller (SDA low on the ninth clock) starts the next byte. A NACK ends the read, and SDA is released.
- R7: In a write, each data byte (MSB first) is stored when its eighth bit is sampled, before the target drives ACK on the ninth clock.
- R8: A START or STOP that arrives before the eighth bit of a data byte drops that byte. The memory and the address latch are left unchanged.
- R9: While wp_i is 1, write data bytes get no ACK, the array is not written and the address does not step. The device and address bytes are still acknowledged.
- R10: A device byte sent straight after a finished write is acknowledged, so there is no busy period.
- R11: sda_oe_o is 0 during and after reset, and it changes only while SCL is low, apart from being released at START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| wp_i | input | 1 | 1 blocks all array writes |

## Verification
The bench aims at several corner cases, and each one shows a specific fault.
- **Wrap and page crossing.** Writes and reads run across a page boundary and across the top of the array. A latch that increments only 8 bits would reread the start of the same page.
- **Protected write.** A protected write is followed by a current-address read. A design that increments or writes under protection returns the wrong byte.
- **Abort mid-byte.** A byte is cut off after a few bits, once by STOP and once by a repeated START. A design that stores or steps early shows a changed byte or a moved address.
- **Wrong device code.** A bad device code is followed by a correct one inside the same transaction. A design that re-arms without a START acknowledges the second byte.

// File: rtl/i2c_fram_pkg.sv
package i2c_fram_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_p  <= scl_sr[STAGES-1];
      sda_p  <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // data edges while clock held high are bus conditions
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_addr_latch.sv
module i2c_addr_latch #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 3,
  localparam int LOW_W = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_page_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              ld_low_i,
  input  logic [LOW_W-1:0]  low_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (ld_low_i)  addr_q[LOW_W-1:0] <= low_i;
    else if (ld_page_i) addr_q[ADDR_W-1:LOW_W] <= page_i;
    else if (inc_i)     addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;

  // R5
  addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !ld_low_i && !ld_page_i && (addr_q == '1) |=> addr_q == '0);

  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !ld_low_i && !ld_page_i |=> $stable(addr_q));
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_fram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-PAGE_W-2:0] TYPE_CODE = 4'b1010,
  localparam int LOW_W = ADDR_W - PAGE_W,
  localparam int CW = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              ld_page_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              ld_low_o,
  output logic [LOW_W-1:0]  low_o,
  output logic              inc_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  tgt_state_e        state_q;
  logic [CW-1:0]     bit_cnt_q;
  logic [DATA_W-1:0] sr_q, tx_q, rx_byte;
  logic              rw_q, ack_ok_q, sda_oe_q;
  logic [1:0]        ph_q;
  logic              last_bit, type_ok;

  assign rx_byte  = {sr_q[DATA_W-2:0], sda_i};
  assign last_bit = scl_rise_i && (bit_cnt_q == LAST);
  assign type_ok  = (rx_byte[DATA_W-1:PAGE_W+1] == TYPE_CODE);
  assign page_o   = rx_byte[PAGE_W:1];
  assign low_o    = rx_byte[LOW_W-1:0];
  assign wdata_o  = rx_byte;
  assign sda_oe_o = sda_oe_q;

  always_comb begin
    ld_page_o = 1'b0;
    ld_low_o  = 1'b0;
    inc_o     = 1'b0;
    mem_we_o  = 1'b0;
    if (!start_i && !stop_i && last_bit) begin
      case (state_q)
        ST_DEV:  ld_page_o = type_ok;
        ST_WADR: ld_low_o  = 1'b1;
        ST_WDAT: begin
          mem_we_o = !wp_i;
          inc_o    = !wp_i;
        end
        ST_RDAT: inc_o = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sr_q      <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      ack_ok_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      ph_q      <= '0;
    end else if (start_i) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
      ph_q      <= '0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
      ph_q     <= '0;
    end else begin
      case (state_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise_i) begin
            sr_q      <= rx_byte;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST) begin
              ph_q <= '0;
              if (state_q == ST_DEV) begin
                ack_ok_q <= type_ok;
                rw_q     <= sda_i;
                state_q  <= ST_DEV_ACK;
              end else if (state_q == ST_WADR) begin
                ack_ok_q <= 1'b1;
                state_q  <= ST_WADR_ACK;
              end else begin
                ack_ok_q <= !wp_i;
                state_q  <= ST_WDAT_ACK;
              end
            end
          end
        end
        ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: begin
          if (scl_fall_i) begin
            if (ph_q == 2'd0) begin
              sda_oe_q <= ack_ok_q;
              ph_q     <= 2'd1;
            end else begin
              sda_oe_q  <= 1'b0;
              ph_q      <= 2'd0;
              bit_cnt_q <= '0;
              if (state_q == ST_DEV_ACK) begin
                if (!ack_ok_q) state_q <= ST_SKIP;
                else if (rw_q) begin
                  state_q  <= ST_RDAT;
                  tx_q     <= rdata_i;
                  sda_oe_q <= ~rdata_i[DATA_W-1];
                end else state_q <= ST_WADR;
              end else begin
                state_q <= ST_WDAT;
              end
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall_i && bit_cnt_q != '0)
            sda_oe_q <= ~tx_q[LAST - bit_cnt_q];
          if (scl_rise_i) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST) begin
              state_q <= ST_RDAT_ACK;
              ph_q    <= 2'd0;
            end
          end
        end
        ST_RDAT_ACK: begin
          if (scl_fall_i && ph_q == 2'd0) begin
            sda_oe_q <= 1'b0;
            ph_q     <= 2'd1;
          end else if (scl_rise_i && ph_q == 2'd1) begin
            if (sda_i) begin
              state_q <= ST_SKIP;
              ph_q    <= 2'd0;
            end else ph_q <= 2'd2;
          end else if (scl_fall_i && ph_q == 2'd2) begin
            state_q   <= ST_RDAT;
            bit_cnt_q <= '0;
            tx_q      <= rdata_i;
            sda_oe_q  <= ~rdata_i[DATA_W-1];
            ph_q      <= 2'd0;
          end
        end
        default: sda_oe_q <= 1'b0;
      endcase
    end
  end

  // R11
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q != $past(sda_oe_q)) && !$past(start_i) && !$past(stop_i) |-> !scl_i);

  // R2
  skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SKIP |-> !sda_oe_q);

  // R7
  store_before_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (state_q == ST_WDAT_ACK) && !sda_oe_q);

  // R6
  release_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RDAT_ACK) && (ph_q == 2'd1) |-> !sda_oe_q);
endmodule

// File: rtl/i2c_fram_target.sv
module i2c_fram_target #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-PAGE_W-2:0] TYPE_CODE = 4'b1010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic wp_i
);
  localparam int LOW_W = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic ld_page, ld_low, inc, mem_we;
  logic [PAGE_W-1:0] page;
  logic [LOW_W-1:0]  low;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_tgt_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .TYPE_CODE(TYPE_CODE)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .wp_i(wp_i), .rdata_i(rdata), .sda_oe_o(sda_oe_o),
    .ld_page_o(ld_page), .page_o(page), .ld_low_o(ld_low), .low_o(low),
    .inc_o(inc), .mem_we_o(mem_we), .wdata_o(wdata)
  );

  i2c_addr_latch #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_page_i(ld_page), .page_i(page),
    .ld_low_i(ld_low), .low_i(low), .inc_i(inc), .addr_o(addr)
  );

  i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i(clk_i), .we_i(mem_we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );
endmodule

// File: tb/sim_i2c_fram_target.sv
module sim_i2c_fram_target;
  localparam int QC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_ln;
  int checks = 0;
  int fails = 0;
  logic [7:0]  ref_mem [2048];
  logic [10:0] exp_addr = '0;

  always #2.5 clk = ~clk;

  assign sda_ln = sda_m & ~sda_oe;

  i2c_fram_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_ln),
    .sda_oe_o(sda_oe), .wp_i(wp)
  );

  localparam logic [18:0] VEC [8] = '{
    {11'h000, 8'h3C}, {11'h0A5, 8'h5A}, {11'h123, 8'hC3}, {11'h2FF, 8'h81},
    {11'h3B0, 8'h7E}, {11'h4D2, 8'h11}, {11'h6EE, 8'hF0}, {11'h7FE, 8'h99}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic q_wait();
    repeat (QC) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait();
    sda_m = 1'b0; q_wait(); scl_m = 1'b0; q_wait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q_wait(); scl_m = 1'b1; q_wait(); sda_m = 1'b1; q_wait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; q_wait(); scl_m = 1'b1; q_wait(); q_wait(); scl_m = 1'b0; q_wait();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait(); b = sda_ln; q_wait();
    scl_m = 1'b0; q_wait();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!give_ack);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] p, input logic rw);
    return {4'b1010, p, rw};
  endfunction

  task automatic do_write(input logic [10:0] a, input int n, input logic [7:0] base);
    logic ack;
    logic [7:0] d;
    bus_start();
    put_byte(dev(a[10:8], 1'b0), ack); check("R1", "write device ack", ack, 1);
    put_byte(a[7:0], ack);             check("R3", "word address ack", ack, 1);
    exp_addr = a;
    for (int k = 0; k < n; k++) begin
      d = base + 8'(k * 7);
      put_byte(d, ack);
      if (!wp) begin
        check("R7", "data ack", ack, 1);
        ref_mem[exp_addr] = d;
        exp_addr = exp_addr + 1'b1;
      end else begin
        check("R9", "protected data nack", ack, 0);
      end
    end
    bus_stop();
  endtask

  // leaves bus open for a repeated start
  task automatic set_addr(input logic [10:0] a);
    logic ack;
    bus_start();
    put_byte(dev(a[10:8], 1'b0), ack); check("R1", "set-address device ack", ack, 1);
    put_byte(a[7:0], ack);             check("R3", "set-address ack", ack, 1);
    exp_addr = a;
  endtask

  task automatic do_read(input logic [2:0] p, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    put_byte(dev(p, 1'b1), ack); check("R1", "read device ack", ack, 1);
    exp_addr[10:8] = p;
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, d);
      check(req, $sformatf("read @%0h", exp_addr), d, ref_mem[exp_addr]);
      exp_addr = exp_addr + 1'b1;
    end
    check("R6", "sda released after nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    check("R11", "oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11", "oe after reset", sda_oe, 0);

    // vector table: single writes then random reads
    for (int v = 0; v < 8; v++) do_write(VEC[v][18:8], 1, VEC[v][7:0]);
    for (int v = 0; v < 8; v++) begin
      set_addr(VEC[v][18:8]);
      do_read(VEC[v][18:16], 1, "R3");
    end

    // page crossing multi-byte write and read
    do_write(11'h0FE, 5, 8'h20);
    set_addr(11'h0FE);
    do_read(3'd0, 5, "R5");

    // top-of-array wrap
    do_write(11'h7FE, 4, 8'hA0);
    set_addr(11'h7FE);
    do_read(3'd7, 4, "R5");

    // current-address read: page 1, low bits continue at 02
    do_read(3'd1, 1, "R4");
    check("R4", "latched address", 32'(exp_addr), 32'h103);

    // no busy period
    do_write(11'h200, 1, 8'h55);
    bus_start();
    put_byte(dev(3'd2, 1'b0), ack); check("R10", "poll right after write", ack, 1);
    bus_stop();

    // write protect
    do_write(11'h0A6, 1, 8'h6B);
    wp = 1'b1;
    do_write(11'h0A5, 2, 8'hEE);
    wp = 1'b0;
    exp_addr = 11'h0A5;
    do_read(3'd0, 2, "R9");

    // abort by STOP mid-byte
    bus_start();
    put_byte(dev(3'd1, 1'b0), ack); check("R1", "abort device ack", ack, 1);
    put_byte(8'h23, ack);           check("R3", "abort address ack", ack, 1);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    exp_addr = 11'h123;
    do_read(3'd1, 1, "R8");

    // abort by repeated START mid-byte
    bus_start();
    put_byte(dev(3'd4, 1'b0), ack); check("R1", "abort2 device ack", ack, 1);
    put_byte(8'hD2, ack);           check("R3", "abort2 address ack", ack, 1);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    exp_addr = 11'h4D2;
    do_read(3'd4, 1, "R8");

    // wrong type code, then a valid code in the same transaction
    bus_start();
    put_byte(8'b1011_0000, ack); check("R2", "bad code nack", ack, 0);
    put_byte(8'hA0, ack);        check("R2", "ignored until start", ack, 0);
    check("R2", "oe idle after bad code", sda_oe, 0);
    bus_stop();
    bus_start();
    put_byte(dev(3'd0, 1'b1), ack); check("R2", "new start re-arms", ack, 1);
    get_byte(1'b0, d);
    bus_stop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule